// File: doc/BRIEF.md
# Register-Mapped General-Purpose I/O Port

This block is a bank of general-purpose I/O lines behind a simple register bus that completes every access in one cycle. The register width is a parameter and sets the number of lines, one line per bit. Software drives lines through an output latch. The latch can be loaded whole, or individual bits can be raised or dropped with write-one-to-set and write-one-to-clear registers. A direction register decides which lines drive their pins. A build parameter chooses whether a 1 in that register means "output" or means "input".

The data register reads back a mix of two sources. Lines that drive return their latched value. Lines that receive return their pin, after the pin has passed through a two-flop synchroniser. The set register reads back the output latch itself, so software can recover what it last drove even on lines that are currently inputs. A second build option reverses the numbering, so that line n sits at register bit WIDTH-1-n in every register.

The register map is word aligned: data at 0x0, set at 0x4, clear at 0x8 and direction at 0xC. The width should be 8, 16, 32 or 64.

Top module: `gpio_mmio_port`

## Requirements
- R1: Reset clears the output latch to 0 and makes every line an input. The direction register then reads all zeros when a 1 means output, and all ones when a 1 means input.
- R2: A write to offset 0x0 loads the whole output latch from the write data. The new value appears on `pin_out` one clock after the write strobe.
- R3: A write to offset 0x4 sets each latch bit whose write bit is 1. Latch bits written with 0 keep their value.
- R4: A write to offset 0x8 clears each latch bit whose write bit is 1. Latch bits written with 0 keep their value.
- R5: With `DIR_ONE_IS_OUT`=1, a direction bit of 1 raises that line's `pin_oe`. With `DIR_ONE_IS_OUT`=0, a direction bit of 1 makes the line an input and lowers its `pin_oe`.
- R6: A read of offset 0x0 returns, per line, the latched value when the line is an output and the synchronised pin when the line is an input.
- R7: A change on an input pin is not visible in a data read after one rising clock edge. It is visible after two.
- R8: A read of offset 0x4 returns the output latch. A read of 0x8 returns 0. A read of 0xC returns the direction register.
- R9: An access to an unmapped address reads 0 and leaves the latch and direction unchanged. Unmapped means address bits [1:0] are nonzero, or any address bit above bit 3 is set.
- R10: With `MIRROR`=1, line n, which is `pin_out[n]`, `pin_oe[n]` and `pin_in[n]`, maps to bit WIDTH-1-n of every register. With `MIRROR`=0 it maps to bit n.
- R11: `bus_rdata` is 0 in every cycle in which `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data, zero when not reading |
| pin_in | input | WIDTH | Asynchronous input pins, line n on bit n |
| pin_out | output | WIDTH | Per-line drive value |
| pin_oe | output | WIDTH | Per-line output enable |

## Verification
The latch is first loaded with an irregular value. Set and clear masks are then applied that overlap it in some bits, miss it in others and touch bits already at the target value. This separates true OR/AND-NOT behaviour from a plain overwrite. Data reads use a direction pattern that splits the word into output and input halves, with pins driven opposite to the latch. A read that takes the wrong source in either half therefore shows. A second instance uses inverted direction polarity and mirrored numbering, with asymmetric values, so that a reversed bit order or a wrong polarity cannot read back correctly. Misaligned and out-of-range writes are followed by readbacks of the latch to show that nothing moved.

// File: rtl/gpio_mmio_port.sv
module gpio_mmio_port #(
  parameter int WIDTH          = 32,
  parameter bit DIR_ONE_IS_OUT = 1'b1,
  parameter bit MIRROR         = 1'b0,
  parameter int ADDR_W         = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe
);

  localparam logic [1:0]       IDX_DATA = 2'd0;
  localparam logic [1:0]       IDX_SET  = 2'd1;
  localparam logic [1:0]       IDX_CLR  = 2'd2;
  localparam logic [1:0]       IDX_DIR  = 2'd3;
  localparam logic [WIDTH-1:0] DIR_RST  = DIR_ONE_IS_OUT ? '0 : '1;

  logic [WIDTH-1:0] latch_q, dir_q, sync1_q, sync2_q;
  logic [WIDTH-1:0] wdata_l, rd_l, rd_bus, data_l;
  logic [1:0]       idx;
  logic             hit;

  assign idx = bus_addr[3:2];
  assign hit = (bus_addr[1:0] == 2'b00) && (bus_addr[ADDR_W-1:4] == '0);

  for (genvar i = 0; i < WIDTH; i++) begin : g_order
    localparam int J = MIRROR ? WIDTH - 1 - i : i;
    assign wdata_l[i] = bus_wdata[J];
    assign rd_bus[J]  = rd_l[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= DIR_RST;
    end else if (bus_wr && hit) begin
      case (idx)
        IDX_DATA: latch_q <= wdata_l;
        IDX_SET:  latch_q <= latch_q | wdata_l;
        IDX_CLR:  latch_q <= latch_q & ~wdata_l;
        default:  dir_q   <= wdata_l;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  assign pin_oe  = DIR_ONE_IS_OUT ? dir_q : ~dir_q;
  assign pin_out = latch_q;
  assign data_l  = (latch_q & pin_oe) | (sync2_q & ~pin_oe);

  always_comb begin
    case (idx)
      IDX_DATA: rd_l = data_l;
      IDX_SET:  rd_l = latch_q;
      IDX_CLR:  rd_l = '0;
      IDX_DIR:  rd_l = dir_q;
      default:  rd_l = '0;
    endcase
  end

  assign bus_rdata = (bus_rd && hit) ? rd_bus : '0;

  // R2
  data_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit && idx == IDX_DATA) |=> pin_out == $past(wdata_l));

  // R3
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit && idx == IDX_SET) |=>
      ((pin_out & $past(wdata_l)) == $past(wdata_l)) &&
      ((pin_out & ~$past(wdata_l)) == ($past(pin_out) & ~$past(wdata_l))));

  // R4
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit && idx == IDX_CLR) |=>
      ((pin_out & $past(wdata_l)) == '0) &&
      ((pin_out & ~$past(wdata_l)) == ($past(pin_out) & ~$past(wdata_l))));

  // R9
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !hit) |=> $stable(pin_out) && $stable(pin_oe));

  // R11
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == '0);

endmodule

// File: tb/tb_gpio_mmio_port.sv
`timescale 1ns/1ps
module tb_gpio_mmio_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [4:0]  a_addr  = '0;
  logic [31:0] a_wdata = '0;
  logic wr_a = 0, rd_a = 0, wr_b = 0, rd_b = 0;
  logic [31:0] pin_a = '0;
  logic [7:0]  pin_b = '0;
  logic [31:0] rdata_a, out_a, oe_a;
  logic [7:0]  rdata_b, out_b, oe_b;

  gpio_mmio_port dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(a_addr), .bus_wr(wr_a), .bus_rd(rd_a),
    .bus_wdata(a_wdata), .bus_rdata(rdata_a), .pin_in(pin_a),
    .pin_out(out_a), .pin_oe(oe_a));

  gpio_mmio_port #(.WIDTH(8), .DIR_ONE_IS_OUT(1'b0), .MIRROR(1'b1)) dut_mir (
    .clk(clk), .rst_n(rst_n), .bus_addr(a_addr), .bus_wr(wr_b), .bus_rd(rd_b),
    .bus_wdata(a_wdata[7:0]), .bus_rdata(rdata_b), .pin_in(pin_b),
    .pin_out(out_b), .pin_oe(oe_b));

  int checks = 0;
  int errors = 0;

  // {is_read, req, addr, data-or-expect, pins}
  localparam int NV = 14;
  localparam logic [73:0] VEC [NV] = '{
    {1'b0, 4'd5,  5'h0C, 32'h0000_FFFF, 32'h0000_0000}, // R5 low half out
    {1'b0, 4'd2,  5'h00, 32'hA5A5_1234, 32'h0000_0000}, // R2
    {1'b1, 4'd6,  5'h00, 32'h5A5A_1234, 32'h5A5A_FFFF}, // R6 mixed sources
    {1'b0, 4'd3,  5'h04, 32'h0000_00C1, 32'h0000_0000}, // R3
    {1'b1, 4'd3,  5'h04, 32'hA5A5_12F5, 32'h0000_0000}, // R3 / R8
    {1'b0, 4'd4,  5'h08, 32'h8000_0034, 32'h0000_0000}, // R4
    {1'b1, 4'd4,  5'h04, 32'h25A5_12C1, 32'h0000_0000}, // R4 / R8
    {1'b1, 4'd8,  5'h08, 32'h0000_0000, 32'h0000_0000}, // R8 clear reads 0
    {1'b1, 4'd8,  5'h0C, 32'h0000_FFFF, 32'h0000_0000}, // R8 direction
    {1'b0, 4'd9,  5'h10, 32'hFFFF_FFFF, 32'h0000_0000}, // R9 out of range
    {1'b0, 4'd9,  5'h06, 32'hFFFF_FFFF, 32'h0000_0000}, // R9 misaligned
    {1'b1, 4'd9,  5'h04, 32'h25A5_12C1, 32'h0000_0000}, // R9 latch kept
    {1'b1, 4'd9,  5'h14, 32'h0000_0000, 32'h0000_0000}, // R9 reads 0
    {1'b1, 4'd6,  5'h00, 32'h0000_12C1, 32'h0000_0000}  // R6 pins low
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input bit b, input logic [4:0] addr, input logic [31:0] data);
    @(negedge clk);
    a_addr = addr; a_wdata = data;
    if (b) wr_b = 1'b1; else wr_a = 1'b1;
    @(negedge clk);
    wr_a = 1'b0; wr_b = 1'b0;
  endtask

  task automatic bus_read(input bit b, input logic [4:0] addr, input logic [31:0] exp, input string req);
    @(negedge clk);
    a_addr = addr;
    if (b) rd_b = 1'b1; else rd_a = 1'b1;
    #1;
    if (b) check(req, {24'h0, rdata_b}, exp); else check(req, rdata_a, exp);
    @(negedge clk);
    rd_a = 1'b0; rd_b = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 out", out_a, 32'h0);
    check("R1 oe", oe_a, 32'h0);
    check("R1 oe mirror", {24'h0, oe_b}, 32'h0);
    bus_read(0, 5'h0C, 32'h0, "R1 dir");
    bus_read(1, 5'h0C, 32'hFF, "R1 dir inverted");

    for (int i = 0; i < NV; i++) begin
      logic [73:0] v;
      v = VEC[i];
      pin_a = v[31:0];
      repeat (3) @(negedge clk);
      if (v[73]) bus_read(0, v[68:64], v[63:32], $sformatf("R%0d vec%0d", v[72:69], i));
      else bus_write(0, v[68:64], v[63:32]);
    end
    check("R2 pin_out", out_a, 32'h25A5_12C1);
    check("R5 pin_oe", oe_a, 32'h0000_FFFF);

    // R7 two-stage input delay
    @(negedge clk);
    pin_a = 32'hFFFF_0000; a_addr = 5'h00; rd_a = 1'b1;
    #1 check("R7 before edge", rdata_a, 32'h0000_12C1);
    @(negedge clk);
    check("R7 one edge", rdata_a, 32'h0000_12C1);
    @(negedge clk);
    check("R7 two edges", rdata_a, 32'hFFFF_12C1);
    rd_a = 1'b0;
    #1 check("R11 idle rdata", rdata_a, 32'h0);

    // R10 mirrored numbering with inverted direction polarity (R5)
    bus_write(1, 5'h0C, 32'h7F);
    bus_write(1, 5'h00, 32'h80);
    check("R10 / R5 oe mirror", {24'h0, oe_b}, 32'h01);
    check("R10 out mirror", {24'h0, out_b}, 32'h01);
    pin_b = 8'h02;
    repeat (3) @(negedge clk);
    bus_read(1, 5'h00, 32'hC0, "R10 data mirror");
    bus_read(1, 5'h04, 32'h80, "R10 set readback");
    bus_read(1, 5'h0C, 32'h7F, "R10 dir readback");
    bus_write(1, 5'h04, 32'h01);
    check("R10 / R3 set mirror", {24'h0, out_b}, 32'h81);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule